// File: doc/BRIEF.md
# Split Row/Column Command Serializer

This block sits between a memory controller's command scheduler and the command pins of one stacked-DRAM channel. The channel has two separate command buses. A narrow row bus carries bank activation, precharge and refresh commands. A wider column bus carries reads, writes and mode-register programming. Each bus has its own valid/ready request port. Every accepted request becomes a pair of half-words per clock: one half-word for the rising edge and one for the falling edge. An output pin stage then places these on the double-data-rate pins.

The two paths do not share state, so a row command and a column command can go out in the same clock. An activate needs more address bits than the row bus can carry in one clock, so it takes two clocks. During the second clock the row port holds off new requests. When no request is accepted, each bus idles with a no-op word. Every word the block emits, no-ops included, carries an even-parity bit in bit 0 of its falling half. All outputs are registered, so a word appears one clock after its request is accepted.

Top module: `cmdser_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the row bus shows rise=6'b111111, fall=6'b000000 and the column bus shows rise=8'hFF, fall=8'h00.
- R2: In every cycle, the XOR of all rising and falling bits of a bus is 0. The parity bit is bit 0 of the falling half and covers every other bit of that cycle.
- R3: An activate (row_op 0) with bank b and row r takes two cycles. Cycle 1: rise = {2'b00,b}, fall[5:1] = r[15:11]. Cycle 2: rise = r[10:5], fall[5:1] = r[4:0].
- R4: row_ready is low for exactly the cycle after an activate is accepted. A request presented then is dropped, and row_ready is high again in the following cycle.
- R5: Precharge (row_op 1) gives rise = {2'b01,b}. Single-bank refresh (row_op 3) gives rise = {2'b10,b}. Both give fall[5:1] = 0.
- R6: Precharge-all (row_op 2) gives rise = 6'b110001. All-bank refresh (row_op 4) gives rise = 6'b110010. Both give fall[5:1] = 0, and bank and address are ignored.
- R7: Read (col_op 0) and write (col_op 1) give rise = {op[1:0], ap, bank[3:0], 1'b0} and fall[7:1] = column address [6:0].
- R8: Mode-register set (col_op 2) gives rise = {2'b10, 2'b00, register number on col_bank}, and fall[7:1] = the 7-bit opcode value on col_addr.
- R9: A cycle with no accepted request idles a bus. A row no-op is rise = 6'b111111, fall[5:1] = 0. A column no-op is rise = 8'hFF, fall[7:1] = 0. col_op 3 requested explicitly also gives a column no-op.
- R10: col_ready is always high outside reset. A column command is emitted in the same cycle as any row word, including the second cycle of an activate.
- R11: row_op values 5, 6 and 7 produce a row no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | Row request present |
| row_ready | output | 1 | Row request accepted this cycle |
| row_op | input | 3 | Row command code (0 act, 1 pre, 2 pre-all, 3 bank refresh, 4 refresh-all) |
| row_bank | input | 4 | Target bank for row command |
| row_addr | input | 16 | Row address for activate |
| col_valid | input | 1 | Column request present |
| col_ready | output | 1 | Column request accepted this cycle |
| col_op | input | 2 | Column command code (0 read, 1 write, 2 mode set, 3 no-op) |
| col_ap | input | 1 | Autoprecharge flag for read/write |
| col_bank | input | 4 | Bank, or mode register number |
| col_addr | input | 7 | Column address, or mode opcode value |
| row_rise | output | 6 | Row half-word for the rising edge |
| row_fall | output | 6 | Row half-word for the falling edge, parity in bit 0 |
| col_rise | output | 8 | Column half-word for the rising edge |
| col_fall | output | 8 | Column half-word for the falling edge, parity in bit 0 |

## Verification
The bench builds the block with its default widths: a 6-bit row bus, an 8-bit column bus, a 4-bit bank and a 16-bit row address. With these widths every field lands at a fixed bit position, so the behavioural model can state each expected word directly. The 16 bank values and the full row address split can all be driven. Random traffic with a high activate rate produces back-to-back activates, requests dropped during the busy cycle, and column commands overlapping both halves of an activate.

// File: rtl/cmdser_pkg.sv
package cmdser_pkg;
  localparam int ROW_W      = 6;
  localparam int COL_W      = 8;
  localparam int BANK_W     = 4;
  localparam int ROW_ADDR_W = 16;
  localparam int COL_ADDR_W = 7;

  localparam logic [2:0] RQ_ACT   = 3'd0;
  localparam logic [2:0] RQ_PRE   = 3'd1;
  localparam logic [2:0] RQ_PREA  = 3'd2;
  localparam logic [2:0] RQ_BREF  = 3'd3;
  localparam logic [2:0] RQ_AREF  = 3'd4;

  typedef enum logic [1:0] {
    CQ_READ  = 2'd0,
    CQ_WRITE = 2'd1,
    CQ_MODE  = 2'd2,
    CQ_IDLE  = 2'd3
  } col_req_e;

  localparam logic [1:0] RPFX_ACT  = 2'b00;
  localparam logic [1:0] RPFX_PRE  = 2'b01;
  localparam logic [1:0] RPFX_BREF = 2'b10;
  localparam logic [1:0] RPFX_NOB  = 2'b11;
  localparam logic [3:0] RSUB_PREA = 4'b0001;
  localparam logic [3:0] RSUB_AREF = 4'b0010;
endpackage

// File: rtl/cmdser_parity.sv
module cmdser_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] rise,
  input  logic [W-2:0] payload,
  output logic         par
);
  always_comb par = ^{rise, payload};
endmodule

// File: rtl/cmdser_row.sv
module cmdser_row
  import cmdser_pkg::*;
#(
  parameter int W      = ROW_W,
  parameter int BANK_W = cmdser_pkg::BANK_W,
  parameter int ADDR_W = ROW_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  output logic              ready,
  input  logic [2:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q
);
  localparam int PAY_W = W - 1;
  localparam int SUB_W = W - 2;

  logic             second_q;
  logic [W-1:0]     mid_q;
  logic [PAY_W-1:0] low_q;
  logic [W-1:0]     nxt_rise;
  logic [PAY_W-1:0] nxt_pay;
  logic             take_act;
  logic             par;

  assign ready = !second_q;

  always_comb begin
    nxt_rise = '1;
    nxt_pay  = '0;
    take_act = 1'b0;
    if (second_q) begin
      nxt_rise = mid_q;
      nxt_pay  = low_q;
    end else if (valid) begin
      case (op)
        RQ_ACT: begin
          nxt_rise = {RPFX_ACT, bank};
          nxt_pay  = addr[ADDR_W-1 -: PAY_W];
          take_act = 1'b1;
        end
        RQ_PRE:  nxt_rise = {RPFX_PRE, bank};
        RQ_BREF: nxt_rise = {RPFX_BREF, bank};
        RQ_PREA: nxt_rise = {RPFX_NOB, SUB_W'(RSUB_PREA)};
        RQ_AREF: nxt_rise = {RPFX_NOB, SUB_W'(RSUB_AREF)};
        default: ;
      endcase
    end
  end

  cmdser_parity #(.W(W)) u_par (.rise(nxt_rise), .payload(nxt_pay), .par(par));

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q   <= '1;
      fall_q   <= {{PAY_W{1'b0}}, 1'(W % 2)};
      second_q <= 1'b0;
      mid_q    <= '0;
      low_q    <= '0;
    end else begin
      rise_q   <= nxt_rise;
      fall_q   <= {nxt_pay, par};
      second_q <= take_act;
      if (take_act) begin
        mid_q <= addr[2*W-2 -: W];
        low_q <= addr[PAY_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmdser_col.sv
module cmdser_col
  import cmdser_pkg::*;
#(
  parameter int W      = COL_W,
  parameter int BANK_W = cmdser_pkg::BANK_W,
  parameter int ADDR_W = COL_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  output logic              ready,
  input  logic [1:0]        op,
  input  logic              ap,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q
);
  localparam int PAY_W  = W - 1;
  localparam int RW_PAD = W - 3 - BANK_W;
  localparam int MR_PAD = W - 2 - BANK_W;

  logic [W-1:0]     nxt_rise;
  logic [PAY_W-1:0] nxt_pay;
  logic             par;

  assign ready = 1'b1;

  always_comb begin
    nxt_rise = '1;
    nxt_pay  = '0;
    if (valid) begin
      case (col_req_e'(op))
        CQ_READ, CQ_WRITE: begin
          nxt_rise = {op, ap, bank, {RW_PAD{1'b0}}};
          nxt_pay  = PAY_W'(addr);
        end
        CQ_MODE: begin
          nxt_rise = {op, {MR_PAD{1'b0}}, bank};
          nxt_pay  = PAY_W'(addr);
        end
        default: ;
      endcase
    end
  end

  cmdser_parity #(.W(W)) u_par (.rise(nxt_rise), .payload(nxt_pay), .par(par));

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '1;
      fall_q <= {{PAY_W{1'b0}}, 1'(W % 2)};
    end else begin
      rise_q <= nxt_rise;
      fall_q <= {nxt_pay, par};
    end
  end
endmodule

// File: rtl/cmdser_top.sv
module cmdser_top
  import cmdser_pkg::*;
#(
  parameter int RW  = ROW_W,
  parameter int CW  = COL_W,
  parameter int BW  = BANK_W,
  parameter int RAW = ROW_ADDR_W,
  parameter int CAW = COL_ADDR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           row_valid,
  output logic           row_ready,
  input  logic [2:0]     row_op,
  input  logic [BW-1:0]  row_bank,
  input  logic [RAW-1:0] row_addr,
  input  logic           col_valid,
  output logic           col_ready,
  input  logic [1:0]     col_op,
  input  logic           col_ap,
  input  logic [BW-1:0]  col_bank,
  input  logic [CAW-1:0] col_addr,
  output logic [RW-1:0]  row_rise,
  output logic [RW-1:0]  row_fall,
  output logic [CW-1:0]  col_rise,
  output logic [CW-1:0]  col_fall
);
  cmdser_row #(.W(RW), .BANK_W(BW), .ADDR_W(RAW)) u_row (
    .clk(clk), .rst(rst), .valid(row_valid), .ready(row_ready),
    .op(row_op), .bank(row_bank), .addr(row_addr),
    .rise_q(row_rise), .fall_q(row_fall)
  );

  cmdser_col #(.W(CW), .BANK_W(BW), .ADDR_W(CAW)) u_col (
    .clk(clk), .rst(rst), .valid(col_valid), .ready(col_ready),
    .op(col_op), .ap(col_ap), .bank(col_bank), .addr(col_addr),
    .rise_q(col_rise), .fall_q(col_fall)
  );
endmodule

// File: rtl/cmdser_chk.sv
module cmdser_chk (
  input logic        clk,
  input logic        rst,
  input logic        row_valid,
  input logic        row_ready,
  input logic [2:0]  row_op,
  input logic [15:0] row_addr,
  input logic        col_valid,
  input logic [5:0]  row_rise,
  input logic [5:0]  row_fall,
  input logic [7:0]  col_rise,
  input logic [7:0]  col_fall
);
  p_row_parity_r2: assert property (@(posedge clk) disable iff (rst)
    ^{row_rise, row_fall} == 1'b0);
  p_col_parity_r2: assert property (@(posedge clk) disable iff (rst)
    ^{col_rise, col_fall} == 1'b0);
  p_act_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_ready && row_op == 3'd0) |=> !row_ready);
  p_busy_single_r4: assert property (@(posedge clk) disable iff (rst)
    !row_ready |=> row_ready);
  p_act_mid_r3: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_ready && row_op == 3'd0) |=> ##1 row_rise == $past(row_addr[10:5], 2));
  p_row_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (row_ready && !row_valid) |=> (row_rise == 6'h3F && row_fall[5:1] == 5'd0));
  p_col_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !col_valid |=> (col_rise == 8'hFF && col_fall == 8'h00));
endmodule

bind cmdser_top cmdser_chk u_chk (
  .clk(clk), .rst(rst), .row_valid(row_valid), .row_ready(row_ready),
  .row_op(row_op), .row_addr(row_addr), .col_valid(col_valid),
  .row_rise(row_rise), .row_fall(row_fall), .col_rise(col_rise), .col_fall(col_fall)
);

// File: tb/tb_cmdser_top.sv
module tb_cmdser_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_valid = 1'b0;
  logic        row_ready;
  logic [2:0]  row_op = '0;
  logic [3:0]  row_bank = '0;
  logic [15:0] row_addr = '0;
  logic        col_valid = 1'b0;
  logic        col_ready;
  logic [1:0]  col_op = '0;
  logic        col_ap = 1'b0;
  logic [3:0]  col_bank = '0;
  logic [6:0]  col_addr = '0;
  logic [5:0]  row_rise, row_fall;
  logic [7:0]  col_rise, col_fall;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0] er_rise, er_fall;
  logic [7:0] ec_rise, ec_fall;
  string      rtag, ctag;
  bit         act_pend;
  logic [5:0] mid_s;
  logic [4:0] low_s;

  always #2 clk = ~clk;

  cmdser_top dut (.*);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] rfall(input logic [5:0] r, input logic [4:0] p);
    return {p, ^{r, p}};
  endfunction

  function automatic logic [7:0] cfall(input logic [7:0] r, input logic [6:0] p);
    return {p, ^{r, p}};
  endfunction

  task automatic compare();
    chk(rtag, "row_rise", 16'(row_rise), 16'(er_rise));
    chk(rtag, "row_fall", 16'(row_fall), 16'(er_fall));
    chk("R4", "row_ready", 16'(row_ready), 16'(!act_pend));
    chk(ctag, "col_rise", 16'(col_rise), 16'(ec_rise));
    chk(ctag, "col_fall", 16'(col_fall), 16'(ec_fall));
    chk("R10", "col_ready", 16'(col_ready), 16'd1);
    chk("R2", "row parity", 16'(^{row_rise, row_fall}), 16'd0);
    chk("R2", "col parity", 16'(^{col_rise, col_fall}), 16'd0);
  endtask

  task automatic cyc(input bit rv, input logic [2:0] rop, input logic [3:0] rb, input logic [15:0] ra,
                     input bit cv, input logic [1:0] cop, input bit cap, input logic [3:0] cb, input logic [6:0] ca);
    logic [5:0] r;
    logic [4:0] p;
    logic [7:0] c;
    logic [6:0] q;
    bool_blk: begin end
    row_valid = rv; row_op = rop; row_bank = rb; row_addr = ra;
    col_valid = cv; col_op = cop; col_ap = cap; col_bank = cb; col_addr = ca;
    r = 6'h3F; p = 5'd0; rtag = "R9";
    if (act_pend) begin
      r = mid_s; p = low_s; rtag = "R3"; act_pend = 1'b0;
    end else if (rv) begin
      case (rop)
        3'd0: begin r = {2'b00, rb}; p = ra[15:11]; mid_s = ra[10:5]; low_s = ra[4:0];
                    act_pend = 1'b1; rtag = "R3"; end
        3'd1: begin r = {2'b01, rb}; rtag = "R5"; end
        3'd3: begin r = {2'b10, rb}; rtag = "R5"; end
        3'd2: begin r = 6'b110001; rtag = "R6"; end
        3'd4: begin r = 6'b110010; rtag = "R6"; end
        default: rtag = "R11";
      endcase
    end
    er_rise = r; er_fall = rfall(r, p);
    c = 8'hFF; q = 7'd0; ctag = "R9";
    if (cv) begin
      case (cop)
        2'd0, 2'd1: begin c = {cop, cap, cb, 1'b0}; q = ca; ctag = "R7"; end
        2'd2: begin c = {2'b10, 2'b00, cb}; q = ca; ctag = "R8"; end
        default: ctag = "R9";
      endcase
      if (rtag == "R3") ctag = "R10";
    end
    ec_rise = c; ec_fall = cfall(c, q);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    act_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset row_rise", 16'(row_rise), 16'h003F);
    chk("R1", "reset row_fall", 16'(row_fall), 16'h0000);
    chk("R1", "reset col_rise", 16'(col_rise), 16'h00FF);
    chk("R1", "reset col_fall", 16'(col_fall), 16'h0000);
    rst = 1'b0;
    er_rise = 6'h3F; er_fall = 6'h00; ec_rise = 8'hFF; ec_fall = 8'h00;
    rtag = "R1"; ctag = "R1";
    @(negedge clk);
    compare();
    // directed: activate with concurrent read, held request during busy cycle
    cyc(1, 3'd0, 4'hF, 16'hA5C3, 1, 2'd0, 1, 4'h9, 7'h55);
    cyc(1, 3'd1, 4'h3, 16'h0,    1, 2'd1, 0, 4'h2, 7'h7F);
    cyc(1, 3'd1, 4'h3, 16'h0,    1, 2'd2, 0, 4'hE, 7'h2A);
    cyc(1, 3'd3, 4'hA, 16'hFFFF, 0, 2'd0, 0, 4'h0, 7'h00);
    cyc(1, 3'd2, 4'h7, 16'h1234, 1, 2'd3, 1, 4'hF, 7'h7F);
    cyc(1, 3'd4, 4'h5, 16'hFFFF, 0, 2'd1, 0, 4'h0, 7'h00);
    cyc(1, 3'd5, 4'h1, 16'h0,    1, 2'd1, 1, 4'h0, 7'h01);
    cyc(1, 3'd7, 4'h1, 16'hFFFF, 0, 2'd0, 0, 4'h0, 7'h00);
    cyc(0, 3'd0, 4'h0, 16'h0,    0, 2'd0, 0, 4'h0, 7'h00);
    cyc(1, 3'd0, 4'h0, 16'hFFFF, 1, 2'd2, 0, 4'h1, 7'h00);
    cyc(1, 3'd0, 4'h1, 16'h0001, 1, 2'd0, 0, 4'h3, 7'h01);
    cyc(1, 3'd0, 4'h2, 16'h8000, 1, 2'd1, 1, 4'h4, 7'h40);
    cyc(0, 3'd0, 4'h0, 16'h0,    0, 2'd0, 0, 4'h0, 7'h00);
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op;
      op = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      cyc(1'($urandom_range(0, 3) != 0), op, 4'($urandom), 16'($urandom),
          1'($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom), 4'($urandom), 7'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule